// File: doc/BRIEF.md
# Bit Set/Clear Control Register Bank

A small bank of 4-bit control registers on a 4-bit processor bus, each one mapped at a pair of neighbouring addresses. A store to the even address of a pair replaces the whole register with the data bus. A store to the odd address is a masked update that changes only some bits. Data bits 0 to 2 pick the register bits to change. Data bit 3 gives the value those picked bits take. Firmware can therefore flip individual control bits without reading the register first, and without racing other code that owns the neighbouring bits.

There is one special rule for the odd address. When a masked store picks none of bits 0 to 2, it acts on register bit 3 alone and copies data bit 3 into it. Bit 3 is therefore reachable through the masked path as well. Reads are combinational from the address, and both addresses of a pair return the same register. The number of registers and the base address are parameters. Register k sits at BASE+2k (whole write) and BASE+2k+1 (masked write).

Top module: `bsr_regbank`

## Requirements
- R1: While rst_ni is low, and after it rises before any write, every register holds 4'b0000.
- R2: A cycle with we_i high and addr_i equal to BASE+2k loads wdata_i into register k at that clock edge.
- R3: A cycle with we_i high, addr_i equal to BASE+2k+1, wdata_i[3]=1 and wdata_i[2:0] not zero sets each bit i (i in 0..2) of register k for which wdata_i[i]=1.
- R4: The same masked store with wdata_i[3]=0 clears each bit i (i in 0..2) of register k for which wdata_i[i]=1.
- R5: In a masked store with wdata_i[2:0] not zero, register bits whose mask bit is 0 keep their value, and register bit 3 keeps its value.
- R6: A masked store with wdata_i[2:0]=3'b000 copies wdata_i[3] into register bit 3 and leaves bits 2..0 unchanged.
- R7: rdata_o shows register k whenever addr_i is BASE+2k or BASE+2k+1, in the same cycle. For any other address it shows 4'b0000.
- R8: A write to an address outside BASE..BASE+2*NUM_REGS-1 changes no register. A write to the pair of register k changes no other register.
- R9: With we_i low, no register changes, whatever addr_i and wdata_i hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (7) | Bus address for both reads and writes |
| we_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data of the addressed register, zero when no register is addressed |

## Verification
A write takes effect at the rising edge where we_i is high, so the updated value is first visible one edge after the strobe. rdata_o follows addr_i with no register in between. The bench therefore drives each write at a falling edge and drops the strobe after the next rising edge. It then presents each read address at a later falling edge and samples 1 ns after it, well before the next rising edge. In this way every sample sees the settled state after exactly one write, and the bench model updates its own copy at the same edge.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned MSK_W = 3;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WHOLE = 2'd1,
    ACC_MASK  = 2'd2
  } acc_e;
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode #(
  parameter int unsigned NUM_REGS  = 2,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned BASE_ADDR = 'h40
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] whole_sel_o,
  output logic [NUM_REGS-1:0] mask_sel_o,
  output logic [NUM_REGS-1:0] any_sel_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_pair
    localparam logic [ADDR_W-1:0] A_WHOLE = ADDR_W'(BASE_ADDR + 2*k);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(BASE_ADDR + 2*k + 1);
    assign whole_sel_o[k] = (addr_i == A_WHOLE);
    assign mask_sel_o[k]  = (addr_i == A_MASK);
    assign any_sel_o[k]   = whole_sel_o[k] | mask_sel_o[k];
  end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  acc_e acc_i,
  input  nib_t wdata_i,
  output nib_t q_o
);
  nib_t q_q, q_d;
  logic [MSK_W-1:0] pick;

  assign pick = wdata_i[MSK_W-1:0];

  always_comb begin
    q_d = q_q;
    unique case (acc_i)
      ACC_WHOLE: q_d = wdata_i;
      ACC_MASK: begin
        if (pick == '0) begin
          // empty mask: act on top bit only
          q_d[NIB_W-1] = wdata_i[NIB_W-1];
        end else if (wdata_i[NIB_W-1]) begin
          q_d[MSK_W-1:0] = q_q[MSK_W-1:0] | pick;
        end else begin
          q_d[MSK_W-1:0] = q_q[MSK_W-1:0] & ~pick;
        end
      end
      default: q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bsr_rdmux.sv
module bsr_rdmux
  import bsr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 2
) (
  input  logic [NUM_REGS-1:0]            sel_i,
  input  logic [NUM_REGS-1:0][NIB_W-1:0] regs_i,
  output nib_t                           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      rdata_o = rdata_o | (regs_i[k] & {NIB_W{sel_i[k]}});
    end
  end
endmodule

// File: rtl/bsr_regbank.sv
module bsr_regbank
  import bsr_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 2,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned BASE_ADDR = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [3:0]        wdata_i,
  output logic [3:0]        rdata_o
);
  logic [NUM_REGS-1:0]            whole_sel, mask_sel, any_sel;
  logic [NUM_REGS-1:0][NIB_W-1:0] regs_q;

  bsr_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr_i     (addr_i),
    .whole_sel_o(whole_sel),
    .mask_sel_o (mask_sel),
    .any_sel_o  (any_sel)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    acc_e acc;
    always_comb begin
      acc = ACC_NONE;
      if (we_i && whole_sel[k])     acc = ACC_WHOLE;
      else if (we_i && mask_sel[k]) acc = ACC_MASK;
    end

    bsr_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acc_i  (acc),
      .wdata_i(wdata_i),
      .q_o    (regs_q[k])
    );
  end

  bsr_rdmux #(.NUM_REGS(NUM_REGS)) u_rdmux (
    .sel_i  (any_sel),
    .regs_i (regs_q),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/bsr_regbank_chk.sv
module bsr_regbank_chk #(
  parameter int unsigned NUM_REGS  = 2,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned BASE_ADDR = 'h40
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      we_i,
  input logic [3:0]                wdata_i,
  input logic [3:0]                rdata_o,
  input logic [NUM_REGS-1:0][3:0]  regs_i
);
  logic miss;
  assign miss = (32'(addr_i) < BASE_ADDR) || (32'(addr_i) >= BASE_ADDR + 2*NUM_REGS);

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> regs_i == '0);

  // R9
  no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_i));

  // R8
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && miss) |=> $stable(regs_i));

  // R7
  miss_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss |-> rdata_o == 4'h0);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_k
    localparam logic [ADDR_W-1:0] A_W = ADDR_W'(BASE_ADDR + 2*k);
    localparam logic [ADDR_W-1:0] A_M = ADDR_W'(BASE_ADDR + 2*k + 1);

    // R2
    whole_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_W) |=> regs_i[k] == $past(wdata_i));

    // R3
    mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_M && wdata_i[3] && wdata_i[2:0] != 3'b000)
      |=> (regs_i[k][2:0] & $past(wdata_i[2:0])) == $past(wdata_i[2:0]));

    // R4
    mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_M && !wdata_i[3] && wdata_i[2:0] != 3'b000)
      |=> (regs_i[k][2:0] & $past(wdata_i[2:0])) == 3'b000);

    // R5
    mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_M && wdata_i[2:0] != 3'b000)
      |=> (regs_i[k][3] == $past(regs_i[k][3])) &&
          ((regs_i[k][2:0] & ~$past(wdata_i[2:0])) == ($past(regs_i[k][2:0]) & ~$past(wdata_i[2:0]))));

    // R6
    empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_M && wdata_i[2:0] == 3'b000)
      |=> regs_i[k] == {$past(wdata_i[3]), $past(regs_i[k][2:0])});

    // R8
    other_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i != A_W && addr_i != A_M) |=> $stable(regs_i[k]));

    // R7
    pair_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == A_W || addr_i == A_M) |-> rdata_o == regs_i[k]);
  end
endmodule

bind bsr_regbank bsr_regbank_chk #(
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .regs_i (regs_q)
);

// File: tb/bsr_regbank_bench.sv
`timescale 1ns/1ps
module bsr_regbank_bench;
  localparam int unsigned N    = 2;
  localparam int unsigned AW   = 7;
  localparam int unsigned BASE = 'h40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [3:0]    wdata = '0;
  logic [3:0]    rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] mdl [N];

  always #5 clk = ~clk;

  bsr_regbank #(.NUM_REGS(N), .ADDR_W(AW), .BASE_ADDR(BASE)) u_bsr_regbank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic in_bank(logic [AW-1:0] a);
    return (32'(a) >= BASE) && (32'(a) < BASE + 2*N);
  endfunction

  function automatic logic [3:0] exp_read(logic [AW-1:0] a);
    if (!in_bank(a)) return 4'h0;
    return mdl[(32'(a) - BASE) / 2];
  endfunction

  function automatic logic [3:0] nxt(logic [3:0] old, logic [3:0] d, logic masked);
    if (!masked) return d;
    if (d[2:0] == 3'b000) return {d[3], old[2:0]};
    if (d[3]) return old | {1'b0, d[2:0]};
    return old & ~{1'b0, d[2:0]};
  endfunction

  function automatic string wr_tag(logic [AW-1:0] a, logic w, logic [3:0] d);
    if (!w) return "R9";
    if (!in_bank(a)) return "R8";
    if (a[0] == BASE[0]) return "R2";
    if (d[2:0] == 3'b000) return "R6";
    return d[3] ? "R3" : "R4";
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [AW-1:0] a, logic w, logic [3:0] d);
    @(negedge clk);
    addr = a; we = w; wdata = d;
    @(posedge clk);
    #1;
    if (w && in_bank(a)) begin
      int k = (32'(a) - BASE) / 2;
      mdl[k] = nxt(mdl[k], d, a[0] != BASE[0]);
    end
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp_read(a));
  endtask

  task automatic rd_all(string req);
    for (int k = 0; k < 2*N; k++) rd(AW'(BASE + k), req);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) mdl[k] = 4'h0;
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    #1 check("R1 in reset", rdata, 4'h0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    rd_all("R1");
    rd(7'h10, "R7 unmapped");

    // R2, R7: whole write, both aliases read
    cyc(7'h40, 1'b1, 4'hA);
    rd(7'h40, "R2");
    rd(7'h41, "R7 alias read");
    rd(7'h42, "R8 neighbour");
    // R3: set bits 0 and 2, bit3 stays
    cyc(7'h41, 1'b1, 4'b1101);
    check("R3 model", mdl[0], 4'hF);
    rd(7'h40, "R3");
    // R4: clear bits 0,1
    cyc(7'h41, 1'b1, 4'b0011);
    rd(7'h41, "R4");
    // R6: empty mask clears / sets bit3
    cyc(7'h41, 1'b1, 4'b0000);
    rd(7'h40, "R6 clear");
    cyc(7'h41, 1'b1, 4'b1000);
    rd(7'h40, "R6 set");
    // R5: clear bit2 only, bit3 (1) untouched
    cyc(7'h41, 1'b1, 4'b0100);
    check("R5 model", mdl[0], 4'b1000);
    rd(7'h40, "R5");
    // R8: out-of-range writes
    cyc(7'h44, 1'b1, 4'hF);
    cyc(7'h3F, 1'b1, 4'h7);
    rd_all("R8");
    // R9: no strobe
    cyc(7'h40, 1'b0, 4'h5);
    cyc(7'h43, 1'b0, 4'hF);
    rd_all("R9");
    // second register, both paths
    cyc(7'h42, 1'b1, 4'h5);
    cyc(7'h43, 1'b1, 4'b1010);
    rd(7'h42, "R3 reg1");
    rd(7'h40, "R8 reg0 kept");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = AW'(32'h3C + $urandom_range(0, 11));
      logic [3:0]    d = 4'($urandom);
      logic          w = ($urandom_range(0, 3) != 0);
      string         t = wr_tag(a, w, d);
      cyc(a, w, d);
      for (int k = 0; k < 2*N; k++) rd(AW'(BASE + k), t);
      rd(AW'($urandom_range(0, 127)), "R7");
    end

    finish_run();
  end
endmodule